// File: doc/BRIEF.md
# Instruction Step Sequencer with Timer Tick

This block runs one architectural step of a processor core at a time. At the start of each step it looks at the interrupt-pending input. If an interrupt is waiting, the step goes straight to the trap target and no fetch is issued. Otherwise it requests a parcel from the fetch unit and waits for the reply. It then combines the fetch status, the verdict of an external decoder and the retire report from the execution datapath. From these it chooses the next program counter, decides whether the instruction retires, and decides whether the trace step count advances. The decoder and the execution datapath are outside the block and report through single-bit inputs.

Every completed step is one loop iteration. A separate divider counts iterations and raises a timer tick and a platform tick together once every programmable number of iterations. When the external done flag is high at the end of a step, the sequencer halts for good. It reports pass for a zero exit code, or fail together with the code, and it gives no tick on that iteration.

Trap, retire and tick indications are single-cycle pulses. They appear in the cycle after the step commits, at the same moment the program counter and step count take their new values.

Top module: `step_sequencer`

## Requirements
- R1: After reset, `pc` equals the RESET_PC parameter, `stepCount` is zero, and `retirePulse`, `trapPulse`, `timerTick`, `platformTick` and `halted` are all low.
- R2: An interrupt pending when a step begins takes priority over fetch. No `fetchReq` is raised in that step, `pc` becomes `trapVec`, nothing retires, `stepCount` is unchanged, and `trapCause` reads 1 with `trapPulse`.
- R3: A fetch reply with `fetchErr` high sets `pc` to `trapVec`, retires nothing, leaves `stepCount` unchanged, and reports `trapCause` 2.
- R4: A parcel with `decodeValid` low raises an illegal-instruction trap. `pc` becomes `trapVec`, nothing retires, `stepCount` rises by one, and `trapCause` reads 3. `illegalBits` holds the offending bits zero-extended to XLEN: the low 16 bits for a compressed parcel, all 32 bits for a base parcel.
- R5: A decoded compressed parcel while `compressedEn` is low neither executes nor retires and raises no trap. `pc` is unchanged and `stepCount` rises by one.
- R6: A parcel whose bits [1:0] are not 2'b11 is compressed. When it decodes and `compressedEn` is high, `pc` advances by 2, `stepCount` rises by one, and the step retires exactly when `execRetired` is high.
- R7: A parcel whose bits [1:0] are 2'b11 is a base instruction. When it decodes, `pc` advances by 4, `stepCount` rises by one, and the step retires exactly when `execRetired` is high.
- R8: `pc` changes only at the end of a step. `retirePulse` is high for exactly one cycle after a retiring step and stays low after any other step.
- R9: With `stepsPerTick` = N > 0, every Nth completed iteration (interrupt and fault steps included) pulses `timerTick` and `platformTick` together, and the iteration count then restarts from zero.
- R10: With `stepsPerTick` = 0, no tick is ever produced.
- R11: If `doneFlag` is high when a step ends, `halted` rises and stays high. `haltPass` is high exactly when `exitCode` is zero, and `haltCode` holds `exitCode`. No tick is produced on that iteration, and no later fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPending | input | 1 | An interrupt is waiting to be taken |
| trapVec | input | XLEN | Target address for interrupts and exceptions |
| fetchReq | output | 1 | Fetch request for the parcel at `pc` |
| fetchDone | input | 1 | Fetch reply valid |
| fetchErr | input | 1 | Fetch reply carries a fault |
| fetchParcel | input | ILEN | Fetched instruction bits |
| decodeValid | input | 1 | External decoder accepted the parcel |
| execRetired | input | 1 | Execution reports the instruction retired |
| compressedEn | input | 1 | Compressed instructions are enabled |
| stepsPerTick | input | TICK_W | Iterations per tick; 0 disables ticking |
| doneFlag | input | 1 | Stop request, sampled at step end |
| exitCode | input | CODE_W | Exit status that goes with the stop request |
| pc | output | XLEN | Architectural program counter, also the fetch address |
| stepCount | output | CNT_W | Trace step count |
| retirePulse | output | 1 | One-cycle retire indication |
| trapPulse | output | 1 | One-cycle trap indication |
| trapCause | output | 2 | 0 none, 1 interrupt, 2 fetch fault, 3 illegal instruction |
| illegalBits | output | XLEN | Zero-extended bits of the last illegal parcel |
| timerTick | output | 1 | Timer tick pulse |
| platformTick | output | 1 | Platform tick pulse |
| halted | output | 1 | Sequencer has stopped |
| haltPass | output | 1 | Stop with zero exit code |
| haltCode | output | CODE_W | Captured exit code |

## Verification
The hardest case to reach is the halting iteration that would also have been a tick iteration. From the ports, the divider count must sit one short of the threshold at the exact step where the done flag is seen. The bench sets the threshold to 1, so every iteration is a tick iteration. It then raises the done flag, which forces the suppression rule to decide the tick output. A second hard case is a compressed parcel that decodes while compressed support is off. The bench reaches it by dropping the enable and supplying a two-bit-tagged parcel with a valid decode.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_IRQ     = 2'd1,
    CAUSE_FETCH   = 2'd2,
    CAUSE_ILLEGAL = 2'd3
  } trapCause_e;

  typedef enum logic [1:0] {
    ST_DECIDE = 2'd0,
    ST_FETCH  = 2'd1,
    ST_COMMIT = 2'd2,
    ST_HALT   = 2'd3
  } seqState_e;

  // strobes from control to datapath and tick divider
  typedef struct packed {
    logic takeIrq;   // step resolved as interrupt
    logic capture;   // fetch reply resolved
    logic commit;    // end of step
    logic finish;    // end of step with stop request
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import step_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqPending,
  input  logic       fetchDone,
  input  logic       doneFlag,
  output seqStrobe_t strobe,
  output logic       fetchReq,
  output logic       halted
);

  seqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_DECIDE: stateD = irqPending ? ST_COMMIT : ST_FETCH;
      ST_FETCH:  if (fetchDone) stateD = ST_COMMIT;
      ST_COMMIT: stateD = doneFlag ? ST_HALT : ST_DECIDE;
      ST_HALT:   stateD = ST_HALT;
      default:   stateD = ST_DECIDE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_DECIDE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.takeIrq = (stateQ == ST_DECIDE) && irqPending;
    strobe.capture = (stateQ == ST_FETCH) && fetchDone;
    strobe.commit  = (stateQ == ST_COMMIT);
    strobe.finish  = (stateQ == ST_COMMIT) && doneFlag;
  end

  assign fetchReq = (stateQ == ST_FETCH);
  assign halted   = (stateQ == ST_HALT);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import step_seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          ILEN     = 32,
  parameter int          CNT_W    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [XLEN-1:0]  trapVec,
  input  logic             fetchErr,
  input  logic [ILEN-1:0]  fetchParcel,
  input  logic             decodeValid,
  input  logic             execRetired,
  input  logic             compressedEn,
  output logic [XLEN-1:0]  pc,
  output logic [CNT_W-1:0] stepCount,
  output logic             retirePulse,
  output logic             trapPulse,
  output logic [1:0]       trapCause,
  output logic [XLEN-1:0]  illegalBits
);

  localparam int HALF = ILEN / 2;
  localparam logic [XLEN-1:0] SHORT_STEP = XLEN'(HALF / 8);
  localparam logic [XLEN-1:0] FULL_STEP  = XLEN'(ILEN / 8);

  // pending outcome of the current step
  logic [XLEN-1:0] nextPcQ, illQ;
  logic            retQ, stepQ;
  trapCause_e      causeQ;

  // classification of the fetch reply
  logic [XLEN-1:0] capNext, capIll;
  logic            capRet, capStep, isShort;
  trapCause_e      capCause;

  assign isShort = (fetchParcel[1:0] != 2'b11);

  always_comb begin
    capNext  = pc;
    capRet   = 1'b0;
    capStep  = 1'b0;
    capCause = CAUSE_NONE;
    capIll   = '0;
    if (fetchErr) begin
      capNext  = trapVec;
      capCause = CAUSE_FETCH;
    end else if (!decodeValid) begin
      capNext  = trapVec;
      capStep  = 1'b1;
      capCause = CAUSE_ILLEGAL;
      capIll   = isShort ? XLEN'(fetchParcel[HALF-1:0]) : XLEN'(fetchParcel);
    end else if (isShort) begin
      capStep = 1'b1;
      if (compressedEn) begin
        capNext = pc + SHORT_STEP;
        capRet  = execRetired;
      end
    end else begin
      capStep = 1'b1;
      capNext = pc + FULL_STEP;
      capRet  = execRetired;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPcQ <= RESET_PC;
      illQ    <= '0;
      retQ    <= 1'b0;
      stepQ   <= 1'b0;
      causeQ  <= CAUSE_NONE;
    end else if (strobe.takeIrq) begin
      nextPcQ <= trapVec;
      retQ    <= 1'b0;
      stepQ   <= 1'b0;
      causeQ  <= CAUSE_IRQ;
    end else if (strobe.capture) begin
      nextPcQ <= capNext;
      illQ    <= capIll;
      retQ    <= capRet;
      stepQ   <= capStep;
      causeQ  <= capCause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc          <= RESET_PC;
      stepCount   <= '0;
      retirePulse <= 1'b0;
      trapPulse   <= 1'b0;
      trapCause   <= CAUSE_NONE;
      illegalBits <= '0;
    end else if (strobe.commit) begin
      pc          <= nextPcQ;
      stepCount   <= stepCount + CNT_W'(stepQ);
      retirePulse <= retQ;
      trapPulse   <= (causeQ != CAUSE_NONE);
      trapCause   <= causeQ;
      if (causeQ == CAUSE_ILLEGAL) illegalBits <= illQ;
    end else begin
      retirePulse <= 1'b0;
      trapPulse   <= 1'b0;
      trapCause   <= CAUSE_NONE;
    end
  end

endmodule

// File: rtl/seq_tick.sv
module seq_tick
  import step_seq_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [TICK_W-1:0] stepsPerTick,
  input  logic [CODE_W-1:0] exitCode,
  output logic              timerTick,
  output logic              platformTick,
  output logic              haltPass,
  output logic [CODE_W-1:0] haltCode
);

  logic [TICK_W-1:0] iterQ;
  logic [TICK_W-1:0] iterNext;
  logic              tickDisabled, reachLimit;

  assign tickDisabled = (stepsPerTick == '0);
  assign iterNext     = iterQ + TICK_W'(1);
  assign reachLimit   = (iterNext == stepsPerTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iterQ        <= '0;
      timerTick    <= 1'b0;
      platformTick <= 1'b0;
    end else begin
      timerTick    <= 1'b0;
      platformTick <= 1'b0;
      if (strobe.commit && !strobe.finish) begin
        if (tickDisabled) begin
          iterQ <= '0;
        end else if (reachLimit) begin
          iterQ        <= '0;
          timerTick    <= 1'b1;
          platformTick <= 1'b1;
        end else begin
          iterQ <= iterNext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltPass <= 1'b0;
      haltCode <= '0;
    end else if (strobe.finish) begin
      haltPass <= (exitCode == '0);
      haltCode <= exitCode;
    end
  end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import step_seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          ILEN     = 32,
  parameter int          CNT_W    = 32,
  parameter int          TICK_W   = 16,
  parameter int          CODE_W   = 8,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPending,
  input  logic [XLEN-1:0]   trapVec,
  output logic              fetchReq,
  input  logic              fetchDone,
  input  logic              fetchErr,
  input  logic [ILEN-1:0]   fetchParcel,
  input  logic              decodeValid,
  input  logic              execRetired,
  input  logic              compressedEn,
  input  logic [TICK_W-1:0] stepsPerTick,
  input  logic              doneFlag,
  input  logic [CODE_W-1:0] exitCode,
  output logic [XLEN-1:0]   pc,
  output logic [CNT_W-1:0]  stepCount,
  output logic              retirePulse,
  output logic              trapPulse,
  output logic [1:0]        trapCause,
  output logic [XLEN-1:0]   illegalBits,
  output logic              timerTick,
  output logic              platformTick,
  output logic              halted,
  output logic              haltPass,
  output logic [CODE_W-1:0] haltCode
);

  seqStrobe_t strobe;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irqPending (irqPending),
    .fetchDone  (fetchDone),
    .doneFlag   (doneFlag),
    .strobe     (strobe),
    .fetchReq   (fetchReq),
    .halted     (halted)
  );

  seq_datapath #(
    .XLEN     (XLEN),
    .ILEN     (ILEN),
    .CNT_W    (CNT_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .trapVec      (trapVec),
    .fetchErr     (fetchErr),
    .fetchParcel  (fetchParcel),
    .decodeValid  (decodeValid),
    .execRetired  (execRetired),
    .compressedEn (compressedEn),
    .pc           (pc),
    .stepCount    (stepCount),
    .retirePulse  (retirePulse),
    .trapPulse    (trapPulse),
    .trapCause    (trapCause),
    .illegalBits  (illegalBits)
  );

  seq_tick #(
    .TICK_W (TICK_W),
    .CODE_W (CODE_W)
  ) u_tick (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .stepsPerTick (stepsPerTick),
    .exitCode     (exitCode),
    .timerTick    (timerTick),
    .platformTick (platformTick),
    .haltPass     (haltPass),
    .haltCode     (haltCode)
  );

endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
  parameter int XLEN   = 32,
  parameter int CNT_W  = 32,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic [XLEN-1:0]   pc,
  input logic [CNT_W-1:0]  stepCount,
  input logic              retirePulse,
  input logic              trapPulse,
  input logic [1:0]        trapCause,
  input logic              timerTick,
  input logic              platformTick,
  input logic              halted,
  input logic [TICK_W-1:0] stepsPerTick
);

  AST_IRQ_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (trapPulse && trapCause == 2'd1) |-> (!retirePulse && $stable(stepCount))); // R2

  AST_FETCH_FAULT_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (trapPulse && trapCause == 2'd2) |-> (!retirePulse && $stable(stepCount))); // R3

  AST_ILLEGAL_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (trapPulse && trapCause == 2'd3) |-> !retirePulse); // R4

  AST_PC_HELD_IN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && $past(fetchReq)) |-> $stable(pc)); // R8

  AST_TICKS_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    timerTick == platformTick); // R9

  AST_TICK_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stepsPerTick) == '0) |-> !timerTick); // R10

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R11

  AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !fetchReq); // R11

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> !timerTick); // R11

endmodule

bind step_sequencer step_sequencer_chk #(
  .XLEN   (XLEN),
  .CNT_W  (CNT_W),
  .TICK_W (TICK_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchReq     (fetchReq),
  .pc           (pc),
  .stepCount    (stepCount),
  .retirePulse  (retirePulse),
  .trapPulse    (trapPulse),
  .trapCause    (trapCause),
  .timerTick    (timerTick),
  .platformTick (platformTick),
  .halted       (halted),
  .stepsPerTick (stepsPerTick)
);

// File: tb/test_step_sequencer.sv
`timescale 1ns/1ps
module test_step_sequencer;

  localparam int XLEN = 32, ILEN = 32, CNT_W = 32, TICK_W = 16, CODE_W = 8;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] TVEC   = 32'h0000_0800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqPending = 1'b0;
  logic [XLEN-1:0] trapVec = TVEC;
  logic fetchReq;
  logic fetchDone = 1'b0, fetchErr = 1'b0;
  logic [ILEN-1:0] fetchParcel = '0;
  logic decodeValid = 1'b0, execRetired = 1'b0, compressedEn = 1'b1;
  logic [TICK_W-1:0] stepsPerTick = '0;
  logic doneFlag = 1'b0;
  logic [CODE_W-1:0] exitCode = '0;
  logic [XLEN-1:0] pc, illegalBits;
  logic [CNT_W-1:0] stepCount;
  logic retirePulse, trapPulse, timerTick, platformTick, halted, haltPass;
  logic [1:0] trapCause;
  logic [CODE_W-1:0] haltCode;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] expPc, expCount;
  int iterCnt = 0;

  always #5 clk = ~clk;

  step_sequencer #(.RESET_PC(RST_PC)) i_step_sequencer (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .trapVec(trapVec),
    .fetchReq(fetchReq), .fetchDone(fetchDone), .fetchErr(fetchErr),
    .fetchParcel(fetchParcel), .decodeValid(decodeValid), .execRetired(execRetired),
    .compressedEn(compressedEn), .stepsPerTick(stepsPerTick), .doneFlag(doneFlag),
    .exitCode(exitCode), .pc(pc), .stepCount(stepCount), .retirePulse(retirePulse),
    .trapPulse(trapPulse), .trapCause(trapCause), .illegalBits(illegalBits),
    .timerTick(timerTick), .platformTick(platformTick), .halted(halted),
    .haltPass(haltPass), .haltCode(haltCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // expected tick of one iteration from R9/R10/R11
  function automatic logic nextTick(input logic done);
    if (done || stepsPerTick == 0) begin
      if (stepsPerTick == 0) iterCnt = 0;
      return 1'b0;
    end
    iterCnt++;
    if (iterCnt == int'(stepsPerTick)) begin
      iterCnt = 0;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    irqPending = 0; fetchDone = 0; doneFlag = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expPc = RST_PC; expCount = 0; iterCnt = 0;
    check("R1 pc", pc, RST_PC);
    check("R1 stepCount", stepCount, 0);
    check("R1 pulses", {retirePulse, trapPulse, timerTick, platformTick, halted}, 0);
  endtask

  task automatic endChecks(input string req, input logic expRet, input logic [1:0] expCause,
                           input logic expTick);
    check({req, " pc"}, pc, expPc);
    check({req, " stepCount"}, stepCount, expCount);
    check({req, " retire"}, retirePulse, expRet);
    check({req, " trapPulse"}, trapPulse, expCause != 0);
    check({req, " cause"}, trapCause, expCause);
    check("R9 timerTick", timerTick, expTick);
    check("R9 platformTick", platformTick, expTick);
  endtask

  // interrupt step: R2
  task automatic stepIrq();
    logic t;
    irqPending = 1'b1;
    @(negedge clk);
    check("R2 no fetch", fetchReq, 0);
    irqPending = 1'b0;
    @(negedge clk);
    expPc = TVEC;
    t = nextTick(doneFlag);
    endChecks("R2", 0, 2'd1, t);
  endtask

  // fetch step; expected outcome derived from R3..R7
  task automatic stepFetch(input string req, input logic [31:0] parcel, input logic err,
                           input logic dv, input logic ret, input logic cen);
    logic eRet, isShort, t;
    logic [1:0] eCause;
    compressedEn = cen;
    @(negedge clk);
    check({req, " fetchReq"}, fetchReq, 1);
    check("R8 retire one cycle", retirePulse, 0);
    fetchDone = 1; fetchErr = err; fetchParcel = parcel; decodeValid = dv; execRetired = ret;
    @(negedge clk);
    fetchDone = 0; fetchErr = 0; decodeValid = 0; execRetired = 0;
    check("R8 pc held", pc, expPc);
    @(negedge clk);
    isShort = parcel[1:0] != 2'b11;
    eRet = 0; eCause = 0;
    if (err) begin
      expPc = TVEC; eCause = 2;
    end else if (!dv) begin
      expPc = TVEC; eCause = 3; expCount++;
      check("R4 illegalBits", illegalBits, isShort ? {16'h0, parcel[15:0]} : parcel);
    end else if (isShort) begin
      expCount++;
      if (cen) begin expPc = expPc + 2; eRet = ret; end
    end else begin
      expCount++; expPc = expPc + 4; eRet = ret;
    end
    t = nextTick(doneFlag);
    endChecks(req, eRet, eCause, t);
  endtask

  task automatic checkHalt(input logic [7:0] code);
    check("R11 halted", halted, 1);
    check("R11 haltPass", haltPass, code == 0);
    check("R11 haltCode", haltCode, code);
    repeat (5) begin
      @(negedge clk);
      check("R11 no fetch after halt", fetchReq, 0);
      check("R11 halted stays", halted, 1);
    end
    check("R11 pc frozen", pc, expPc);
  endtask

  initial begin
    doReset();
    // tick disabled throughout this block (R10)
    stepFetch("R7", 32'h0000_0013, 0, 1, 1, 1);
    stepFetch("R7", 32'h0040_0093, 0, 1, 0, 1);
    stepFetch("R6", 32'h0000_0001, 0, 1, 1, 1);
    stepFetch("R6", 32'h0000_4502, 0, 1, 0, 1);
    stepFetch("R5", 32'h0000_4501, 0, 1, 1, 0);
    stepFetch("R4", 32'hFFFF_FFFF, 0, 0, 1, 1);
    stepFetch("R4", 32'hABCD_1234, 0, 0, 1, 1);
    stepFetch("R3", 32'h0000_0013, 1, 1, 1, 1);
    stepIrq();
    check("R10 no tick seen", iterCnt, 0);
    // R9: tick every 3 iterations, interrupt and fault included
    stepsPerTick = 3;
    stepFetch("R7", 32'h0000_0013, 0, 1, 1, 1);
    stepIrq();
    stepFetch("R3", 32'h0000_0013, 1, 1, 1, 1);
    stepFetch("R6", 32'h0000_0001, 0, 1, 1, 1);
    stepFetch("R7", 32'h0000_0013, 0, 1, 1, 1);
    stepFetch("R7", 32'h0000_0013, 0, 1, 1, 1);
    // R11: stop with nonzero code on an iteration that would tick
    stepsPerTick = 1;
    doneFlag = 1; exitCode = 8'h05;
    stepFetch("R11", 32'h0000_0013, 0, 1, 1, 1);
    checkHalt(8'h05);
    // second run: tick every iteration, then stop with zero code via interrupt step
    doReset();
    stepsPerTick = 1;
    stepFetch("R9", 32'h0000_0013, 0, 1, 1, 1);
    stepIrq();
    doneFlag = 1; exitCode = 8'h00;
    stepIrq();
    checkHalt(8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule